// File: doc/BRIEF.md
# Multiplexed Converter Serial Interface Slave

This block is the device side of a chip-select framed serial link for an 8-bit converter that has a 12-input multiplexer. It runs entirely on the continuous conversion clock. The serial clock, the active-low chip select and the serial data input arrive asynchronously. Each is resynchronized, and its edges are detected in the conversion-clock domain.

An exchange lasts eight serial clock cycles. While the host shifts in a channel address, MSB first, on the first four rising edges, the block returns the previous 8-bit result. The top bit is visible as soon as chip select falls. The remaining seven bits follow on successive falling edges.

The eighth falling edge starts a behavioural conversion. The conversion lasts a fixed, parameter-chosen number of conversion-clock cycles, and at its end the block captures a sample value that the environment supplies. A chip select that stays low past the end of the conversion starts the next exchange at once. A chip-select change that does not belong to the protocol aborts the exchange or the conversion in progress. After an abort, the data is marked invalid until a full conversion has finished.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset, busy, dataValid, abortSeen, chanSel and the stored result are all zero, and doOe is low while csNIn is high.
- R2: doOe equals the inverse of the raw csNIn with no clock delay. While chip select is low, before any serial clock edge, doOut shows bit 7 of the stored result.
- R3: The channel address is taken MSB first from dataIn on the first four serial clock rising edges of an exchange. Rising edges five to eight do not change it.
- R4: Serial clock falling edges one to seven each present the next lower result bit on doOut (bits 6 down to 0). Each new bit appears within three clock cycles of the edge.
- R5: The eighth falling edge starts a conversion. busy is high for exactly CONV_CYCLES clock cycles (default 56, legal range 48 to 64), and chanSel takes the new address and holds it while busy is high.
- R6: Address values 12 to 15 select channel 0.
- R7: A chip-select low pulse shorter than one clock period is ignored, so no exchange starts and abortSeen stays 0. Serial clock edges while chip select is high have no effect.
- R8: If chip select is still low when a conversion ends, the next exchange starts with no chip-select toggle, and it returns the new result.
- R9: Chip select going high for at least three clock periods during an exchange aborts it. busy stays 0, dataValid clears and abortSeen sets.
- R10: Chip select returning low for at least three clock periods during a conversion aborts the conversion. busy drops, dataValid clears, abortSeen sets and a new exchange begins, which returns the stale stored result.
- R11: At the end of a completed conversion, the stored result takes the value of sampleIn and dataValid sets. dataValid stays clear after an abort until such a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous conversion clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Asynchronous serial clock |
| csNIn | input | 1 | Asynchronous active-low chip select |
| dataIn | input | 1 | Serial address input |
| sampleIn | input | 8 | Value captured as the result at the end of a conversion |
| doOut | output | 1 | Serial result output |
| doOe | output | 1 | Output enable for doOut (high = driven) |
| chanSel | output | 4 | Selected multiplexer channel |
| busy | output | 1 | Conversion in progress |
| dataValid | output | 1 | Stored result is from a completed, unaborted conversion |
| abortSeen | output | 1 | Sticky flag: an abort has occurred since reset |

## Verification
The assertions check on every cycle that:
- chanSel stays within the 12 channels and is stable throughout a conversion;
- every completed conversion lasts between 48 and 64 cycles;
- dataValid rises only as busy ends;
- an abort always leaves the block idle or transferring with dataValid cleared, and abortSeen never clears.

Only the bench's scenarios can show the serial behaviour at the pins:
- the bit order of returned data and address capture;
- glitch rejection on chip select;
- the back-to-back exchange with chip select held low;
- the stale data returned after a conversion is aborted.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_CONV
  } sifState_e;

  typedef struct packed {
    logic loadOut;
    logic shiftOut;
    logic shiftAddr;
    logic latchChan;
    logic loadResult;
    logic dropValid;
  } dpStrobe_t;

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic dataIn,
  output logic csLow,
  output logic csFall,
  output logic sclkRise,
  output logic sclkFall,
  output logic dinSync
);

  logic csA, csB, csQ, csQPrev;
  logic sA, sB, sC;
  logic dA, dB;

  // Chip select: two-flop synchronizer; the qualified level only changes
  // when both stages agree, which rejects sub-period pulses.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csA     <= 1'b1;
      csB     <= 1'b1;
      csQ     <= 1'b1;
      csQPrev <= 1'b1;
    end else begin
      csA     <= csNIn;
      csB     <= csA;
      if (csA == csB) csQ <= csB;
      csQPrev <= csQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sA <= 1'b0;
      sB <= 1'b0;
      sC <= 1'b0;
      dA <= 1'b0;
      dB <= 1'b0;
    end else begin
      sA <= sclkIn;
      sB <= sA;
      sC <= sB;
      dA <= dataIn;
      dB <= dA;
    end
  end

  assign csLow    = ~csQ;
  assign csFall   = ~csQ & csQPrev;
  assign sclkRise = sB & ~sC;
  assign sclkFall = ~sB & sC;
  assign dinSync  = dB;

endmodule

// File: rtl/adc_sif_ctrl.sv
module adc_sif_ctrl
  import adc_sif_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int ADDR_BITS   = 4,
  parameter int CONV_CYCLES = 56
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csLow,
  input  logic      csFall,
  input  logic      sclkRise,
  input  logic      sclkFall,
  output dpStrobe_t stb,
  output logic      busy,
  output logic      abortSeen
);

  localparam int BIT_W = $clog2(BITS);
  localparam int CNT_W = $clog2(CONV_CYCLES);

  sifState_e        state, nState;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] convCnt;
  logic             abortHit;

  always_comb begin
    stb      = '0;
    nState   = state;
    abortHit = 1'b0;
    case (state)
      ST_IDLE: if (csLow) nState = ST_XFER;
      ST_XFER: begin
        if (!csLow) begin
          nState        = ST_IDLE;
          stb.loadOut   = 1'b1;
          stb.dropValid = 1'b1;
          abortHit      = 1'b1;
        end else begin
          if (sclkRise && (32'(bitCnt) < ADDR_BITS)) stb.shiftAddr = 1'b1;
          if (sclkFall) begin
            if (bitCnt == BIT_W'(BITS - 1)) begin
              nState        = ST_CONV;
              stb.latchChan = 1'b1;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end
        end
      end
      ST_CONV: begin
        if (csFall) begin
          nState        = ST_XFER;
          stb.loadOut   = 1'b1;
          stb.dropValid = 1'b1;
          abortHit      = 1'b1;
        end else if (convCnt == CNT_W'(CONV_CYCLES - 1)) begin
          stb.loadResult = 1'b1;
          nState         = csLow ? ST_XFER : ST_IDLE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      convCnt   <= '0;
      abortSeen <= 1'b0;
    end else begin
      state <= nState;
      if (nState == ST_XFER && state != ST_XFER) bitCnt <= '0;
      else if (state == ST_XFER && sclkFall) bitCnt <= bitCnt + 1'b1;
      if (state != ST_CONV) convCnt <= '0;
      else convCnt <= convCnt + 1'b1;
      if (abortHit) abortSeen <= 1'b1;
    end
  end

  assign busy = (state == ST_CONV);

endmodule

// File: rtl/adc_sif_dp.sv
module adc_sif_dp
  import adc_sif_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int ADDR_BITS = 4,
  parameter int NUM_CH    = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic                 dinSync,
  input  logic [BITS-1:0]      sampleIn,
  output logic                 doBit,
  output logic [ADDR_BITS-1:0] chanSel,
  output logic                 dataValid
);

  logic [BITS-1:0]      outSr, resultReg;
  logic [ADDR_BITS-1:0] addrSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSr     <= '0;
      resultReg <= '0;
      addrSr    <= '0;
      chanSel   <= '0;
      dataValid <= 1'b0;
    end else begin
      if (stb.loadResult) begin
        resultReg <= sampleIn;
        outSr     <= sampleIn;
        dataValid <= 1'b1;
      end else if (stb.loadOut) begin
        outSr <= resultReg;
      end else if (stb.shiftOut) begin
        outSr <= {outSr[BITS-2:0], 1'b0};
      end
      if (stb.dropValid) dataValid <= 1'b0;
      if (stb.shiftAddr) addrSr <= {addrSr[ADDR_BITS-2:0], dinSync};
      if (stb.latchChan) chanSel <= (32'(addrSr) < NUM_CH) ? addrSr : '0;
    end
  end

  assign doBit = outSr[BITS-1];

endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adc_sif_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int ADDR_BITS   = 4,
  parameter int NUM_CH      = 12,
  parameter int CONV_CYCLES = 56
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkIn,
  input  logic                 csNIn,
  input  logic                 dataIn,
  input  logic [BITS-1:0]      sampleIn,
  output logic                 doOut,
  output logic                 doOe,
  output logic [ADDR_BITS-1:0] chanSel,
  output logic                 busy,
  output logic                 dataValid,
  output logic                 abortSeen
);

  logic      csLow, csFall, sclkRise, sclkFall, dinSync;
  dpStrobe_t stb;

  adc_sif_sync u_sync (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .dataIn(dataIn),
    .csLow(csLow), .csFall(csFall), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .dinSync(dinSync)
  );

  adc_sif_ctrl #(.BITS(BITS), .ADDR_BITS(ADDR_BITS), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csLow(csLow), .csFall(csFall),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .stb(stb),
    .busy(busy), .abortSeen(abortSeen)
  );

  adc_sif_dp #(.BITS(BITS), .ADDR_BITS(ADDR_BITS), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dinSync(dinSync), .sampleIn(sampleIn),
    .doBit(doOut), .chanSel(chanSel), .dataValid(dataValid)
  );

  // Output enable follows the raw pin so the MSB is visible at once.
  assign doOe = ~csNIn;

endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk #(
  parameter int ADDR_BITS = 4,
  parameter int NUM_CH    = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_BITS-1:0] chanSel,
  input logic                 busy,
  input logic                 dataValid,
  input logic                 abortSeen
);

  localparam int MIN_CONV = 48;
  localparam int MAX_CONV = 64;

  logic [7:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  a_r6_chan_in_range: assert property (@(posedge clk) disable iff (!rstN)
    32'(chanSel) < NUM_CH);

  a_r5_chan_stable_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(chanSel));

  a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> 32'(runLen) < MAX_CONV);

  a_r5_conv_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && dataValid |-> (32'(runLen) >= MIN_CONV && 32'(runLen) <= MAX_CONV));

  a_r11_valid_at_conv_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(busy));

  a_r9_abort_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortSeen) |-> (!dataValid && !busy));

  a_r10_abort_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(abortSeen));

endmodule

bind adc_serial_slave adc_serial_slave_chk #(.ADDR_BITS(ADDR_BITS), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .chanSel(chanSel), .busy(busy),
  .dataValid(dataValid), .abortSeen(abortSeen)
);

// File: tb/adc_serial_slave_bench.sv
module adc_serial_slave_bench;

  localparam int CONV = 56;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclkIn = 1'b0;
  logic       csNIn = 1'b1;
  logic       dataIn = 1'b0;
  logic [7:0] sampleIn = 8'hA5;
  logic       doOut, doOe, busy, dataValid, abortSeen;
  logic [3:0] chanSel;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] expQ[$];
  logic [7:0] gotQ[$];
  event gotEv;
  logic [7:0] lastResult = 8'h00;
  int runCnt = 0;
  int lastRun = 0;

  adc_serial_slave u_adc_serial_slave (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .dataIn(dataIn),
    .sampleIn(sampleIn), .doOut(doOut), .doOe(doOe), .chanSel(chanSel),
    .busy(busy), .dataValid(dataValid), .abortSeen(abortSeen)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (busy) runCnt <= runCnt + 1;
    else if (runCnt != 0) begin
      lastRun <= runCnt;
      runCnt  <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each returned byte against the expected queue.
  initial begin
    forever begin
      @(gotEv);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        logic [7:0] g, e;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        check(g == e, "R4 returned byte", int'(g), int'(e));
      end
    end
  end

  task automatic exchange(input logic [3:0] addr, input bit keepLow);
    logic [7:0] got;
    expQ.push_back(lastResult);
    @(negedge clk);
    csNIn = 1'b0;
    #1;
    check(doOe == 1'b1, "R2 doOe on cs fall", int'(doOe), 1);
    check(doOut == lastResult[7], "R2 msb before clock", int'(doOut), int'(lastResult[7]));
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      dataIn = (i < 4) ? addr[3-i] : 1'b1;
      repeat (4) @(negedge clk);
      got[7-i] = doOut;
      sclkIn = 1'b1;
      repeat (4) @(negedge clk);
      sclkIn = 1'b0;
    end
    gotQ.push_back(got);
    ->gotEv;
    repeat (2) @(negedge clk);
    if (!keepLow) begin
      csNIn = 1'b1;
      #1;
      check(doOe == 1'b0, "R2 doOe on cs rise", int'(doOe), 0);
    end
  endtask

  task automatic waitConv(input logic [3:0] expChan);
    wait (busy);
    wait (!busy);
    repeat (2) @(negedge clk);
    check(lastRun == CONV, "R5 busy length", lastRun, CONV);
    check(chanSel == expChan, "R5/R6 chanSel", int'(chanSel), int'(expChan));
    check(dataValid == 1'b1, "R11 valid after conversion", int'(dataValid), 1);
    lastResult = sampleIn;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    check(dataValid == 1'b0, "R1 valid reset", int'(dataValid), 0);
    check(abortSeen == 1'b0, "R1 abort reset", int'(abortSeen), 0);
    check(chanSel == 4'd0, "R1 chan reset", int'(chanSel), 0);
    check(doOe == 1'b0, "R1 doOe idle", int'(doOe), 0);

    // R3: ones on rises 5-8 must not disturb address 5
    exchange(4'd5, 1'b0);
    waitConv(4'd5);
    sampleIn = 8'h3C;

    // R7: glitch on chip select, and serial clock while deselected
    @(negedge clk);
    #3 csNIn = 1'b0;
    #5 csNIn = 1'b1;
    repeat (10) @(negedge clk);
    check(abortSeen == 1'b0, "R7 glitch ignored", int'(abortSeen), 0);
    check(busy == 1'b0, "R7 glitch no busy", int'(busy), 0);
    for (int k = 0; k < 3; k++) begin
      sclkIn = 1'b1; repeat (4) @(negedge clk);
      sclkIn = 1'b0; repeat (4) @(negedge clk);
    end
    check(busy == 1'b0, "R7 sclk ignored while deselected", int'(busy), 0);

    // R6: address 13 maps to channel 0
    exchange(4'd13, 1'b0);
    waitConv(4'd0);
    sampleIn = 8'h96;

    // R8: chip select held low across conversion end
    exchange(4'd11, 1'b1);
    waitConv(4'd11);
    sampleIn = 8'h5A;
    exchange(4'd2, 1'b0);
    waitConv(4'd2);

    // R9: abort during an exchange
    @(negedge clk);
    csNIn = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sclkIn = 1'b1; repeat (4) @(negedge clk);
      sclkIn = 1'b0; repeat (4) @(negedge clk);
    end
    csNIn = 1'b1;
    repeat (6) @(negedge clk);
    check(abortSeen == 1'b1, "R9 abort flagged", int'(abortSeen), 1);
    check(dataValid == 1'b0, "R9 valid cleared", int'(dataValid), 0);
    check(busy == 1'b0, "R9 not busy", int'(busy), 0);
    sampleIn = 8'hC3;
    exchange(4'd7, 1'b0);
    waitConv(4'd7);

    // R10: abort during a conversion by returning chip select low
    exchange(4'd4, 1'b0);
    wait (busy);
    repeat (10) @(negedge clk);
    csNIn = 1'b0;
    repeat (6) @(negedge clk);
    check(busy == 1'b0, "R10 conversion aborted", int'(busy), 0);
    check(dataValid == 1'b0, "R10 valid cleared", int'(dataValid), 0);
    check(chanSel == 4'd4, "R10 chan latched", int'(chanSel), 4);
    sampleIn = 8'h1F;
    exchange(4'd9, 1'b0);
    waitConv(4'd9);
    exchange(4'd0, 1'b0);
    waitConv(4'd0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule